// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, address and control pins of an SDRAM from reset until the memory can accept ordinary traffic. After reset it holds the pins at NOP, with clock enable and all byte masks high, for a programmable settling time. It then closes every bank with one precharge-all command. After that it issues the mode register load and a programmable number of auto-refresh commands. A build parameter picks which of these two comes first. Once the last timing gap has passed, it raises a done flag that stays high.

The mode register word is built from four configuration inputs: burst length, burst ordering, CAS latency and write mode. If the burst length or the latency code is one the memory does not define, the sequencer flags an error and does not leave the settling state. All timing is given in nanoseconds together with the clock period, and each interval is rounded up to whole cycles. Each command is placed at the earliest cycle its timing allows.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset release, the pins carry NOP for exactly PAUSE_CYC = ceil(PAUSE_NS/CLK_NS) cycles. Clock enable and every mask bit stay high during the whole sequence.
- R2: When the settling time has elapsed, a precharge command is issued in the following cycle with address bit 10 set, which closes all banks. This is the first non-NOP command.
- R3: The command after the precharge comes ceil(T_RP_NS/CLK_NS) cycles after it.
- R4: Exactly N_REF auto-refresh commands are issued. Consecutive refreshes are exactly ceil(T_RC_NS/CLK_NS) cycles apart.
- R5: With MRS_FIRST=0 the order is precharge, the refreshes, then the mode register load. With MRS_FIRST=1 the order is precharge, the mode register load, then the refreshes.
- R6: The mode register load drives the following address bits. Bits 2..0 carry the burst length code (000=1, 001=2, 010=4, 011=8, 111=full page). Bit 3 carries the ordering (0 sequential, 1 interleave). Bits 6..4 carry the latency code (010=2, 011=3). Bit 9 carries the write mode (0 burst write, 1 single write). All other address bits and both bank bits are 0.
- R7: The command that follows a mode register load comes ceil(T_MRD_NS/CLK_NS) cycles after it.
- R8: init_done_o rises one full gap after the last command of the sequence: the refresh gap, or the mode register gap when the load comes last. It then stays high, and the pins stay at NOP.
- R9: A burst length code of 100, 101 or 110, or a latency code other than 010 or 011, raises cfg_err_o before done. While it is raised the pins stay at NOP. Once the code becomes valid after the settling time has elapsed, the precharge follows on the next cycle.
- R10: Commands are encoded on (cs_n, ras_n, cas_n, we_n) as NOP=0111, precharge=0010, refresh=0001 and mode register load=0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_len_i | input | 3 | Burst length code |
| burst_ilv_i | input | 1 | Burst ordering, 1 = interleave |
| cas_lat_i | input | 3 | CAS latency code |
| single_wr_i | input | 1 | 1 = single-location writes |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| dqm_o | output | DQM_W | Byte masks |
| addr_o | output | ADDR_W | Address bus |
| ba_o | output | BA_W | Bank address |
| init_done_o | output | 1 | Sequence finished |
| cfg_err_o | output | 1 | Reserved configuration code present |

## Verification
The bench builds two instances with the settling time shortened to 2 us. The first uses a 20 ns clock with MRS_FIRST=0, which makes the precharge and mode register gaps a single cycle; this reaches the path where a command state moves straight on to the next command without a wait state. The second uses a 10 ns clock with MRS_FIRST=1, which gives gaps of 2, 7 and 2 cycles; this reaches the wait states and the order in which the mode register load comes first. The first instance also goes through every legal burst length code and through both reserved-code paths.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    S_PAUSE, S_PRE, S_WAIT_RP, S_REF, S_WAIT_RC, S_MRS, S_WAIT_MRD, S_DONE
  } init_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned W    = 8,
  parameter int unsigned INIT = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= W'(INIT);
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [2:0]        burst_len_i,
  input  logic              burst_ilv_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              single_wr_i,
  output logic [ADDR_W-1:0] word_o,
  output logic              valid_o
);
  logic len_ok, lat_ok;

  always_comb begin
    word_o      = '0;
    word_o[2:0] = burst_len_i;
    word_o[3]   = burst_ilv_i;
    word_o[6:4] = cas_lat_i;
    word_o[9]   = single_wr_i;
  end

  // 100..110 are undefined burst lengths
  assign len_ok  = (burst_len_i[2] == 1'b0) || (burst_len_i == 3'b111);
  assign lat_ok  = (cas_lat_i == 3'd2) || (cas_lat_i == 3'd3);
  assign valid_o = len_ok && lat_ok;
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned TW        = 8,
  parameter int unsigned N_REF     = 8,
  parameter int unsigned RP_CYC    = 1,
  parameter int unsigned RC_CYC    = 4,
  parameter int unsigned MRD_CYC   = 1,
  parameter bit          MRS_FIRST = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_ok_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output sdram_cmd_e    cmd_o,
  output logic          done_o
);
  localparam int unsigned RW     = $clog2(N_REF + 1);
  localparam int unsigned RP_LD  = (RP_CYC  > 1) ? RP_CYC  - 2 : 0;
  localparam int unsigned RC_LD  = (RC_CYC  > 1) ? RC_CYC  - 2 : 0;
  localparam int unsigned MRD_LD = (MRD_CYC > 1) ? MRD_CYC - 2 : 0;

  init_state_e state_q, state_d;
  logic [RW-1:0] ref_q, refs_done;
  init_state_e after_rp, after_rc, after_mrd;

  always_comb begin
    refs_done = ref_q + RW'(state_q == S_REF);
    after_rp  = MRS_FIRST ? S_MRS : S_REF;
    after_rc  = (refs_done == RW'(N_REF)) ? (MRS_FIRST ? S_DONE : S_MRS) : S_REF;
    after_mrd = MRS_FIRST ? S_REF : S_DONE;
  end

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cmd_o      = CMD_NOP;
    unique case (state_q)
      S_PAUSE: if (tmr_zero_i && cfg_ok_i) state_d = S_PRE;
      S_PRE: begin
        cmd_o = CMD_PRE;
        if (RP_CYC <= 1) state_d = after_rp;
        else begin state_d = S_WAIT_RP; tmr_load_o = 1'b1; tmr_val_o = TW'(RP_LD); end
      end
      S_WAIT_RP: if (tmr_zero_i) state_d = after_rp;
      S_REF: begin
        cmd_o = CMD_REF;
        if (RC_CYC <= 1) state_d = after_rc;
        else begin state_d = S_WAIT_RC; tmr_load_o = 1'b1; tmr_val_o = TW'(RC_LD); end
      end
      S_WAIT_RC: if (tmr_zero_i) state_d = after_rc;
      S_MRS: begin
        cmd_o = CMD_MRS;
        if (MRD_CYC <= 1) state_d = after_mrd;
        else begin state_d = S_WAIT_MRD; tmr_load_o = 1'b1; tmr_val_o = TW'(MRD_LD); end
      end
      S_WAIT_MRD: if (tmr_zero_i) state_d = after_mrd;
      default: state_d = S_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_PAUSE;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_REF) ref_q <= ref_q + 1'b1;
    end
  end

  assign done_o = (state_q == S_DONE);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned PAUSE_NS  = 200000,
  parameter int unsigned T_RP_NS   = 20,
  parameter int unsigned T_RC_NS   = 68,
  parameter int unsigned T_MRD_NS  = 16,
  parameter int unsigned N_REF     = 8,
  parameter bit          MRS_FIRST = 1'b0,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned DQM_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_ilv_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              single_wr_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [DQM_W-1:0]  dqm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              init_done_o,
  output logic              cfg_err_o
);
  localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_NS);
  localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int unsigned RC_CYC    = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int unsigned MRD_CYC   = ns_to_cyc(T_MRD_NS, CLK_NS);
  localparam int unsigned GAP_MAX   = (RC_CYC > RP_CYC) ? ((RC_CYC > MRD_CYC) ? RC_CYC : MRD_CYC)
                                                        : ((RP_CYC > MRD_CYC) ? RP_CYC : MRD_CYC);
  localparam int unsigned T_MAX     = (PAUSE_CYC > GAP_MAX) ? PAUSE_CYC : GAP_MAX;
  localparam int unsigned TW        = $clog2(T_MAX + 1);

  logic              cfg_ok, tmr_zero, tmr_load;
  logic [TW-1:0]     tmr_val;
  logic [ADDR_W-1:0] mode_word;
  sdram_cmd_e        cmd;

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_word (
    .burst_len_i (burst_len_i),
    .burst_ilv_i (burst_ilv_i),
    .cas_lat_i   (cas_lat_i),
    .single_wr_i (single_wr_i),
    .word_o      (mode_word),
    .valid_o     (cfg_ok)
  );

  sdram_init_timer #(.W(TW), .INIT(PAUSE_CYC - 1)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sdram_init_fsm #(
    .TW(TW), .N_REF(N_REF), .RP_CYC(RP_CYC), .RC_CYC(RC_CYC),
    .MRD_CYC(MRD_CYC), .MRS_FIRST(MRS_FIRST)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_ok_i   (cfg_ok),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .cmd_o      (cmd),
    .done_o     (init_done_o)
  );

  always_comb begin
    addr_o = '0;
    if (cmd == CMD_MRS)      addr_o = mode_word;
    else if (cmd == CMD_PRE) addr_o[10] = 1'b1;  // all banks
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd;
  assign ba_o      = '0;
  assign cke_o     = 1'b1;
  assign dqm_o     = '1;
  assign cfg_err_o = !cfg_ok && !init_done_o;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned RC_CYC  = 4,
  parameter int unsigned MRD_CYC = 1,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned BA_W    = 2,
  parameter int unsigned DQM_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [DQM_W-1:0]  dqm_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BA_W-1:0]   ba_o,
  input logic              init_done_o,
  input logic              cfg_err_o
);
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  logic [3:0]  cmd, last_q;
  logic [15:0] gap_q;

  assign cmd = {cs_no, ras_no, cas_no, we_no};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= C_NOP;
      gap_q  <= '0;
    end else if (cmd != C_NOP) begin
      last_q <= cmd;
      gap_q  <= 16'd1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) cke_o && (&dqm_o)); // R1
  AST_PRE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni) (cmd == C_PRE) |-> addr_o[10]); // R2
  AST_RC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == C_REF && last_q == C_REF) |-> (gap_q >= 16'(RC_CYC))); // R4
  AST_MRS_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == C_MRS) |-> ((addr_o[6:4] == 3'd2 || addr_o[6:4] == 3'd3) && addr_o[8:7] == 2'b00
                        && addr_o[ADDR_W-1:10] == '0 && ba_o == '0)); // R6
  AST_MRD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != C_NOP && last_q == C_MRS) |-> (gap_q >= 16'(MRD_CYC))); // R7
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) init_done_o |=> init_done_o); // R8
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) init_done_o |-> (cmd == C_NOP)); // R8
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (cmd == C_NOP && !init_done_o)); // R9
  AST_LEGAL_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == C_NOP || cmd == C_PRE || cmd == C_REF || cmd == C_MRS); // R10
endmodule

bind sdram_init_seq sdram_init_chk #(
  .RC_CYC(RC_CYC), .MRD_CYC(MRD_CYC), .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_o(cke_o), .cs_no(cs_no), .ras_no(ras_no),
  .cas_no(cas_no), .we_no(we_no), .dqm_o(dqm_o), .addr_o(addr_o), .ba_o(ba_o),
  .init_done_o(init_done_o), .cfg_err_o(cfg_err_o)
);

// File: tb/sim_sdram_init_seq.sv
`timescale 1ns/1ps
module sim_sdram_init_seq;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  // {burst_len, interleave, cas_lat, single_wr, expected mode word}
  localparam int NV = 5;
  localparam logic [19:0] VEC [NV] = '{
    {3'd0, 1'b0, 3'd2, 1'b0, 12'h020},
    {3'd1, 1'b1, 3'd3, 1'b0, 12'h039},
    {3'd2, 1'b0, 3'd3, 1'b1, 12'h232},
    {3'd3, 1'b1, 3'd2, 1'b1, 12'h22B},
    {3'd7, 1'b0, 3'd2, 1'b0, 12'h027}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bl = 3'd3, cl = 3'd2;
  logic bt = 1'b0, wm = 1'b0;
  int checks = 0, fails = 0, cyc = 0;
  bit msel = 1'b0;

  logic cke0, cs0, ras0, cas0, we0, done0, err0, cke1, cs1, ras1, cas1, we1, done1, err1;
  logic [7:0] dqm0, dqm1;
  logic [11:0] a0, a1;
  logic [1:0] ba0, ba1;

  always #10 clk = ~clk;

  sdram_init_seq #(.CLK_NS(20), .PAUSE_NS(2000), .MRS_FIRST(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .burst_len_i(bl), .burst_ilv_i(bt), .cas_lat_i(cl),
    .single_wr_i(wm), .cke_o(cke0), .cs_no(cs0), .ras_no(ras0), .cas_no(cas0), .we_no(we0),
    .dqm_o(dqm0), .addr_o(a0), .ba_o(ba0), .init_done_o(done0), .cfg_err_o(err0));

  sdram_init_seq #(.CLK_NS(10), .PAUSE_NS(2000), .MRS_FIRST(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .burst_len_i(bl), .burst_ilv_i(bt), .cas_lat_i(cl),
    .single_wr_i(wm), .cke_o(cke1), .cs_no(cs1), .ras_no(ras1), .cas_no(cas1), .we_no(we1),
    .dqm_o(dqm1), .addr_o(a1), .ba_o(ba1), .init_done_o(done1), .cfg_err_o(err1));

  wire [3:0]  m_cmd  = msel ? {cs1, ras1, cas1, we1} : {cs0, ras0, cas0, we0};
  wire [11:0] m_addr = msel ? a1 : a0;
  wire [1:0]  m_ba   = msel ? ba1 : ba0;
  wire        m_hold = msel ? (cke1 && &dqm1) : (cke0 && &dqm0);
  wire        m_done = msel ? done1 : done0;
  wire        m_err  = msel ? err1 : err0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] nbl, input logic nbt, input logic [2:0] ncl, input logic nwm);
    @(negedge clk);
    rst_n = 1'b0;
    bl = nbl; bt = nbt; cl = ncl; wm = nwm;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_one(input bit sel, input int p, input int rp, input int rc, input int mrd,
                         input bit mf, input logic [19:0] v);
    int exp_cyc[10];
    logic [3:0] exp_cmd[10];
    int t, k, n, done_at;
    bit hold_ok, quiet_ok;
    msel = sel;
    exp_cyc[0] = p; exp_cmd[0] = PRE;
    t = p + rp;
    if (mf) begin
      exp_cyc[1] = t; exp_cmd[1] = MRS; t += mrd;
      for (int i = 0; i < 8; i++) begin exp_cyc[2+i] = t; exp_cmd[2+i] = REF; t += rc; end
    end else begin
      for (int i = 0; i < 8; i++) begin exp_cyc[1+i] = t; exp_cmd[1+i] = REF; t += rc; end
      exp_cyc[9] = t; exp_cmd[9] = MRS; t += mrd;
    end
    done_at = t;
    do_reset(v[19:17], v[16], v[15:13], v[12]);
    chk(m_cmd == NOP && !m_done, "R1", "state at reset release", {m_done, m_cmd}, NOP);
    k = 0; n = 0; hold_ok = 1'b1;
    while (n < done_at + 20) begin
      @(negedge clk);
      n++;
      if (!m_hold) hold_ok = 1'b0;
      if (m_cmd != NOP) begin
        if (k < 10) begin
          chk(m_cmd == exp_cmd[k], "R10", "command code", m_cmd, exp_cmd[k]);
          chk(n == exp_cyc[k], (k == 0) ? "R1" : (k == 1) ? "R3" : "R4", "command cycle", n, exp_cyc[k]);
          if (m_cmd == PRE) chk(m_addr[10], "R2", "precharge A10", m_addr, 12'h400);
          if (m_cmd == MRS) chk(m_addr == v[11:0] && m_ba == 2'b00, "R6", "mode word", m_addr, v[11:0]);
        end
        k++;
      end
      if (m_done) break;
    end
    chk(k == 10, "R5", "command count", k, 10);
    chk(n == done_at, mf ? "R8" : "R7", "done cycle", n, done_at);
    chk(hold_ok, "R1", "cke/dqm held high", hold_ok, 1);
    chk(!m_err, "R9", "no error on legal config", m_err, 0);
    quiet_ok = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (m_cmd != NOP || !m_done) quiet_ok = 1'b0;
    end
    chk(quiet_ok, "R8", "idle and done after finish", quiet_ok, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit quiet;
    // table: u0, refresh before mode load
    for (int i = 0; i < NV; i++) run_one(1'b0, 100, 1, 4, 1, 1'b0, VEC[i]);
    // u1: mode load first, multi-cycle gaps
    run_one(1'b1, 200, 2, 7, 2, 1'b1, VEC[2]);

    // R9: reserved burst length holds the sequencer in the pause
    msel = 1'b0;
    do_reset(3'b100, 1'b0, 3'd2, 1'b0);
    quiet = 1'b1;
    repeat (150) begin
      @(negedge clk);
      if (m_cmd != NOP || !m_err) quiet = 1'b0;
    end
    chk(quiet, "R9", "reserved burst length stalls with error", quiet, 1);
    bl = 3'd2;
    @(negedge clk);
    chk(m_cmd == PRE, "R9", "precharge one cycle after valid config", m_cmd, PRE);
    chk(!m_err, "R9", "error clears", m_err, 0);

    // R9: reserved latency code
    do_reset(3'd1, 1'b0, 3'b001, 1'b0);
    repeat (5) @(negedge clk);
    chk(m_err && m_cmd == NOP, "R9", "reserved latency flags error", {m_err, m_cmd}, {1'b1, NOP});
    do_reset(3'd1, 1'b0, 3'b100, 1'b0);
    repeat (120) @(negedge clk);
    chk(m_err && m_cmd == NOP && !m_done, "R9", "latency 100 stalls", {m_done, m_err, m_cmd}, {1'b0, 1'b1, NOP});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule